// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block holds the replacement state for every set of a set-associative cache and names the way to evict when a fill is needed. Each set owns a binary decision tree with one bit per internal node, which is NUM_WAYS-1 bits for NUM_WAYS ways. A hit or a fill to a way is reported on the access port. The tree of that set is then rewritten so that every node on the path to that way points away from it. A victim request on a separate set index walks the tree of that set from the root. It takes the older half at each node and returns the way it reaches.

The tree keeps only a partial order, so the chosen way is close to the least recently used one but can differ from it. The victim port only reads the state. The cache controller reports the fill of the returned way through the access port. Both ports may name the same set in one cycle. In that case the victim comes from the tree as it stood before that cycle's update.

Top module: `plru_victim_sel`

## Requirements
- R1: Every set holds NUM_WAYS-1 tree bits, and reset clears all of them. A victim request to any set after reset returns way 0.
- R2: An access with acc_valid_i high sets every node on the path to acc_way_i so that it points to the other half. A victim request issued in the cycle after an access to the same set never returns the accessed way.
- R3: Node encoding: a node value of 0 marks the left half (lower way numbers) as older and 1 marks the right half as older. Nodes are stored heap-ordered: node 0 is the root and node n has children 2n+1 and 2n+2. The victim walk takes the older half at each level, and the decision at the root is the most significant bit of the way number.
- R4: vic_valid_o goes high exactly one cycle after vic_req_i, with vic_way_o valid in that cycle. In a cycle after no request, vic_valid_o is low and vic_way_o keeps its last value.
- R5: A victim request does not change any tree, so repeated requests to a set with no access in between return the same way.
- R6: An access changes only the tree of the set it names. Victims of all other sets are unaffected.
- R7: When an access and a victim request name the same set in one cycle, the victim is taken from the tree before that access.
- R8: Ways 0,5,4,7,3,2,1,6 are accessed in that order on a fresh set. The victim is then way 3 (binary 011), while the least recently used way is 0.
- R9: While acc_valid_i is low, acc_set_i and acc_way_i have no effect on any tree.
- R10: Ways 0 through 7 are accessed in ascending order on a fresh set. The victim is then way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A hit or fill is reported this cycle |
| acc_set_i | input | SET_W | Set index of the access |
| acc_way_i | input | WAY_W | Way that was hit or filled |
| vic_req_i | input | 1 | Victim request this cycle |
| vic_set_i | input | SET_W | Set index of the victim request |
| vic_valid_o | output | 1 | Victim result valid |
| vic_way_o | output | WAY_W | Way chosen for replacement |

## Verification
The bound checker watches the result handshake on every cycle. It checks that a result follows each request by exactly one cycle, that no result appears without a request, and that the way holds between results. It also checks that a request made just after an access to the same set never names the accessed way. The exact victim produced by a sequence of accesses can only be shown by the bench scenarios: the fixed eight-access order, ascending fills, isolation between sets, ignored accesses with valid low, and a same-set access and request in one cycle. A reference tree model in the bench supplies the expected way for each of these scenarios and for a long pseudo-random mix.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Variant of the victim result path.
   typedef enum logic {
      VIC_COMB = 1'b0,   // result in the request cycle
      VIC_FLOP = 1'b1    // result one cycle after the request
   } vic_mode_e;

   // Index of the first node of a tree level in heap order.
   function automatic int level_base(input int lv);
      return (1 << lv) - 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
   parameter int NUM_SETS = 16,
   parameter int NODE_N   = 7,
   parameter int SET_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [SET_W-1:0]  wr_set_i,
   input  logic [NODE_N-1:0] wr_tree_i,
   input  logic [SET_W-1:0]  rd_a_set_i,
   output logic [NODE_N-1:0] rd_a_tree_o,
   input  logic [SET_W-1:0]  rd_b_set_i,
   output logic [NODE_N-1:0] rd_b_tree_o
);

   logic [NUM_SETS-1:0][NODE_N-1:0] tree_all;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic [NODE_N-1:0] tree_q;
      logic              sel;

      assign sel = wr_en_i && (wr_set_i == SET_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tree_q <= '0;
         end else if (sel) begin
            tree_q <= wr_tree_i;
         end
      end

      assign tree_all[s] = tree_q;
   end

   assign rd_a_tree_o = tree_all[rd_a_set_i];
   assign rd_b_tree_o = tree_all[rd_b_set_i];

endmodule

// File: rtl/plru_path_update.sv
module plru_path_update #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input  logic [NUM_WAYS-2:0] tree_i,
   input  logic [WAY_W-1:0]    way_i,
   output logic [NUM_WAYS-2:0] tree_o
);

   localparam int NODE_N = NUM_WAYS - 1;
   localparam int LEVELS = WAY_W;

   // Mask of the touched nodes and the values they take, built per level.
   logic [LEVELS:0][NODE_N-1:0] msk_chain;
   logic [LEVELS:0][NODE_N-1:0] val_chain;

   assign msk_chain[0] = '0;
   assign val_chain[0] = '0;

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      localparam int BASE = plru_pkg::level_base(lv);
      logic [WAY_W-1:0]  prefix;
      logic [NODE_N-1:0] node_sel;

      // Upper way bits select the node inside this level.
      assign prefix   = way_i >> (LEVELS - lv);
      assign node_sel = NODE_N'(1) << (prefix + WAY_W'(BASE));

      assign msk_chain[lv+1] = msk_chain[lv] | node_sel;
      // The node points away from the half that holds the way.
      assign val_chain[lv+1] = val_chain[lv] |
                               (way_i[LEVELS-1-lv] ? '0 : node_sel);
   end

   assign tree_o = (tree_i & ~msk_chain[LEVELS]) | val_chain[LEVELS];

endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input  logic [NUM_WAYS-2:0] tree_i,
   output logic [WAY_W-1:0]    way_o
);

   localparam int LEVELS = WAY_W;

   logic [LEVELS-1:0][WAY_W-1:0] idx_c;
   logic [LEVELS-1:0]            dir_c;

   assign idx_c[0] = '0;

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      assign dir_c[lv]             = tree_i[idx_c[lv]];
      assign way_o[LEVELS-1-lv]    = dir_c[lv];
      if (lv < LEVELS - 1) begin : g_next
         assign idx_c[lv+1] = (idx_c[lv] << 1) + WAY_W'(1) + WAY_W'(dir_c[lv]);
      end
   end

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
   parameter int                  NUM_WAYS = 8,
   parameter int                  NUM_SETS = 16,
   parameter int                  WAY_W    = $clog2(NUM_WAYS),
   parameter int                  SET_W    = $clog2(NUM_SETS),
   parameter plru_pkg::vic_mode_e VIC_MODE = plru_pkg::VIC_FLOP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid_i,
   input  logic [SET_W-1:0] acc_set_i,
   input  logic [WAY_W-1:0] acc_way_i,
   input  logic             vic_req_i,
   input  logic [SET_W-1:0] vic_set_i,
   output logic             vic_valid_o,
   output logic [WAY_W-1:0] vic_way_o
);

   localparam int NODE_N = NUM_WAYS - 1;

   // Elaboration-time parameter checks.
   if (!plru_pkg::is_pow2(NUM_WAYS)) begin : g_bad_ways
      $error("plru_victim_sel: NUM_WAYS must be a power of two, at least 2");
   end
   if (!plru_pkg::is_pow2(NUM_SETS)) begin : g_bad_sets
      $error("plru_victim_sel: NUM_SETS must be a power of two, at least 2");
   end
   if (WAY_W != $clog2(NUM_WAYS)) begin : g_bad_way_w
      $error("plru_victim_sel: WAY_W must equal clog2(NUM_WAYS)");
   end
   if (SET_W != $clog2(NUM_SETS)) begin : g_bad_set_w
      $error("plru_victim_sel: SET_W must equal clog2(NUM_SETS)");
   end

   logic [NODE_N-1:0] acc_tree_rd;
   logic [NODE_N-1:0] acc_tree_nx;
   logic [NODE_N-1:0] vic_tree_rd;
   logic [WAY_W-1:0]  vic_way_nx;

   plru_tree_store #(
      .NUM_SETS (NUM_SETS),
      .NODE_N   (NODE_N),
      .SET_W    (SET_W)
   ) i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (acc_valid_i),
      .wr_set_i    (acc_set_i),
      .wr_tree_i   (acc_tree_nx),
      .rd_a_set_i  (acc_set_i),
      .rd_a_tree_o (acc_tree_rd),
      .rd_b_set_i  (vic_set_i),
      .rd_b_tree_o (vic_tree_rd)
   );

   plru_path_update #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) i_update (
      .tree_i (acc_tree_rd),
      .way_i  (acc_way_i),
      .tree_o (acc_tree_nx)
   );

   // The walk reads the stored tree, so a same-set update this cycle is not seen.
   plru_tree_walk #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) i_walk (
      .tree_i (vic_tree_rd),
      .way_o  (vic_way_nx)
   );

   if (VIC_MODE == plru_pkg::VIC_FLOP) begin : g_vic_flop
      logic             vic_valid_q;
      logic [WAY_W-1:0] vic_way_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vic_valid_q <= 1'b0;
            vic_way_q   <= '0;
         end else begin
            vic_valid_q <= vic_req_i;
            if (vic_req_i) begin
               vic_way_q <= vic_way_nx;
            end
         end
      end

      assign vic_valid_o = vic_valid_q;
      assign vic_way_o   = vic_way_q;
   end else begin : g_vic_comb
      assign vic_valid_o = vic_req_i;
      assign vic_way_o   = vic_way_nx;
   end

endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
   parameter int                  WAY_W    = 3,
   parameter int                  SET_W    = 4,
   parameter plru_pkg::vic_mode_e VIC_MODE = plru_pkg::VIC_FLOP
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid_i,
   input logic [SET_W-1:0] acc_set_i,
   input logic [WAY_W-1:0] acc_way_i,
   input logic             vic_req_i,
   input logic [SET_W-1:0] vic_set_i,
   input logic             vic_valid_o,
   input logic [WAY_W-1:0] vic_way_o
);

   // Access seen in the previous cycle.
   logic             last_v_q;
   logic [SET_W-1:0] last_set_q;
   logic [WAY_W-1:0] last_way_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_v_q   <= 1'b0;
         last_set_q <= '0;
         last_way_q <= '0;
      end else begin
         last_v_q   <= acc_valid_i;
         last_set_q <= acc_set_i;
         last_way_q <= acc_way_i;
      end
   end

   if (VIC_MODE == plru_pkg::VIC_FLOP) begin : g_flop_props
      // R4
      assert_result_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
         vic_req_i |=> vic_valid_o);
      // R4
      assert_no_spurious_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !vic_req_i |=> !vic_valid_o);
      // R4
      assert_way_holds_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !vic_req_i |=> $stable(vic_way_o));
      // R2
      assert_victim_not_just_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (last_v_q && vic_req_i && (vic_set_i == last_set_q))
         |=> (vic_way_o != $past(last_way_q)));
      // R3
      assert_way_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
         vic_valid_o |-> !$isunknown(vic_way_o));
   end

endmodule

bind plru_victim_sel plru_victim_sel_chk #(
   .WAY_W    (WAY_W),
   .SET_W    (SET_W),
   .VIC_MODE (VIC_MODE)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid_i (acc_valid_i),
   .acc_set_i   (acc_set_i),
   .acc_way_i   (acc_way_i),
   .vic_req_i   (vic_req_i),
   .vic_set_i   (vic_set_i),
   .vic_valid_o (vic_valid_o),
   .vic_way_o   (vic_way_o)
);

// File: tb/test_plru_victim_sel.sv
`timescale 1ns/1ps
module test_plru_victim_sel;

   localparam int WAYS = 8;
   localparam int SETS = 16;
   localparam int WW   = 3;
   localparam int SW   = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid_i;
   logic [SW-1:0] acc_set_i;
   logic [WW-1:0] acc_way_i;
   logic          vic_req_i;
   logic [SW-1:0] vic_set_i;
   logic          vic_valid_o;
   logic [WW-1:0] vic_way_o;

   always #2.5 clk = ~clk;

   plru_victim_sel #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) i_plru_victim_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid_i (acc_valid_i),
      .acc_set_i   (acc_set_i),
      .acc_way_i   (acc_way_i),
      .vic_req_i   (vic_req_i),
      .vic_set_i   (vic_set_i),
      .vic_valid_o (vic_valid_o),
      .vic_way_o   (vic_way_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   logic [WW-1:0] exp_way_q [$];
   string         exp_tag_q [$];
   logic [WAYS-2:0] mdl [SETS];

   logic          last_valid;
   logic [WW-1:0] last_way;

   // Reference tree from the requirements: heap order, 0 = left older (R3).
   function automatic logic [WW-1:0] mdl_pick(input logic [WAYS-2:0] t);
      logic [WW-1:0] w = '0;
      int n = 0;
      for (int lv = 0; lv < WW; lv++) begin
         w[WW-1-lv] = t[n];
         n = 2*n + 1 + (t[n] ? 1 : 0);
      end
      return w;
   endfunction

   function automatic logic [WAYS-2:0] mdl_touch(input logic [WAYS-2:0] t,
                                                 input logic [WW-1:0] w);
      int n = 0;
      for (int lv = 0; lv < WW; lv++) begin
         t[n] = ~w[WW-1-lv];
         n = 2*n + 1 + (w[WW-1-lv] ? 1 : 0);
      end
      return t;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Driver: one cycle of stimulus; pushes the expected victim to the scoreboard.
   task automatic step(input bit av, input int as_, input int aw,
                       input bit vr, input int vs, input string tag);
      @(negedge clk);
      last_valid  = vic_valid_o;
      last_way    = vic_way_o;
      acc_valid_i = av;
      acc_set_i   = SW'(as_);
      acc_way_i   = WW'(aw);
      vic_req_i   = vr;
      vic_set_i   = SW'(vs);
      if (vr) begin
         exp_way_q.push_back(mdl_pick(mdl[vs]));   // pre-update state (R7)
         exp_tag_q.push_back(tag);
      end
      if (av) mdl[as_] = mdl_touch(mdl[as_], WW'(aw));
   endtask

   task automatic idle();
      step(1'b0, 0, 0, 1'b0, 0, "");
   endtask

   // Monitor: pops and compares results as they appear.
   always @(negedge clk) begin
      if (mon_on && vic_valid_o) begin
         if (exp_way_q.size() == 0) begin
            check("R4 unexpected result", 1, 0);
         end else begin
            check(exp_tag_q.pop_front(), int'(vic_way_o), int'(exp_way_q.pop_front()));
         end
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int s = 0; s < SETS; s++) mdl[s] = '0;
      rst_n = 1'b0; acc_valid_i = 0; acc_set_i = 0; acc_way_i = 0;
      vic_req_i = 0; vic_set_i = 0;
      repeat (4) @(negedge clk);
      check("R1 reset valid", int'(vic_valid_o), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R1: fresh sets give way 0
      step(0, 0, 0, 1, 0, "R1 set0");
      step(0, 0, 0, 1, 15, "R1 set15");
      idle();
      check("R1 set15 direct", int'(last_way), 0);

      // R8: fixed order on set 3
      step(1, 3, 0, 0, 0, ""); step(1, 3, 5, 0, 0, "");
      step(1, 3, 4, 0, 0, ""); step(1, 3, 7, 0, 0, "");
      step(1, 3, 3, 0, 0, ""); step(1, 3, 2, 0, 0, "");
      step(1, 3, 1, 0, 0, ""); step(1, 3, 6, 0, 0, "");
      step(0, 0, 0, 1, 3, "R8");
      // R5: second request with no access in between
      step(0, 0, 0, 1, 3, "R5");
      check("R8 direct", int'(last_way), 3);
      idle();
      check("R5 direct", int'(last_way), 3);
      idle();
      // R4: no request, result low and way held
      check("R4 idle valid", int'(last_valid), 0);
      check("R4 idle hold", int'(last_way), 3);

      // R9: access with valid low must not touch set 3
      step(0, 3, 3, 0, 0, "");
      step(0, 0, 0, 1, 3, "R9");
      idle();
      check("R9 direct", int'(last_way), 3);

      // R7: access and request on same set in one cycle
      step(1, 3, 3, 1, 3, "R7 pre");
      step(0, 0, 0, 1, 3, "R7 post");
      check("R7 pre direct", int'(last_way), 3);
      idle();
      check("R7 post direct", int'(last_way), 5);

      // R6: traffic on set 4 leaves set 3 alone
      step(1, 4, 1, 0, 0, ""); step(1, 4, 6, 0, 0, ""); step(1, 4, 2, 0, 0, "");
      step(0, 0, 0, 1, 3, "R6");
      idle();
      check("R6 direct", int'(last_way), 5);

      // R2: victim after access is not the accessed way
      step(1, 5, 6, 0, 0, "");
      step(0, 0, 0, 1, 5, "R2");
      idle();
      check("R2 direct", int'(last_way != 3'd6), 1);

      // R10: ascending fills on set 6
      for (int w = 0; w < WAYS; w++) step(1, 6, w, 0, 0, "");
      step(0, 0, 0, 1, 6, "R10");
      idle();
      check("R10 direct", int'(last_way), 0);

      // R3: pseudo-random mix checked against the reference tree
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], int'({1'b0, lfsr[3:1]}), int'(lfsr[6:4]),
              lfsr[7], int'({1'b0, lfsr[9], lfsr[2], lfsr[8]}), "R3 mix");
      end
      idle(); idle();
      check("R4 scoreboard drained", exp_way_q.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule